// File: doc/BRIEF.md
# Timer Tick Prescaler and Divider Tree

This block turns one peripheral clock into five count-enable streams for a five-channel timer unit. Two shared prescalers reduce the clock rate by a programmable factor. Channels 0 and 1 take their ticks from the first prescaler, and channels 2, 3 and 4 take theirs from the second. Each channel then passes those ticks through its own power-of-two divider. Instead of the divider, a channel can select an external tick input. Channels 0 and 1 share external input 0, and channels 2 to 4 share external input 1.

Configuration comes in as two static words. The prescaler word holds both prescale values. The select word holds one 4-bit code per channel, so a single write sets the divide ratio and the source choice together. Each output is a one-cycle enable pulse in the peripheral clock domain, ready to gate a timer counter.

Top module: `tick_tree`

## Requirements
- R1: Prescaler 0 takes its value from pre_cfg_i[7:0] and prescaler 1 from pre_cfg_i[15:8]. A prescaler with value V yields one enable every V+1 clock cycles.
- R2: Channels 0 and 1 use prescaler 0 and external input bit 0. Channels 2, 3 and 4 use prescaler 1 and external input bit 1.
- R3: The select code of channel c sits in sel_cfg_i[4c+3:4c]. A code n in 0..3 makes the channel tick once every 2^(n+1) prescaler enables, so the steady period is (V+1)*2^(n+1) cycles.
- R4: Code 4 routes the channel's synchronised external rising edges to its output. With this code, no tick occurs unless an external rising edge arrives.
- R5: Codes 5 to 15 behave as divide by 16.
- R6: An external input that rises just before clock edge k produces a tick_o pulse that is visible after edge k+2 and not before it.
- R7: Each external rising edge gives exactly one single-cycle pulse, however long the input stays high. No output is ever high on two consecutive cycles.
- R8: When a channel's select code changes, its divider restarts from zero. With prescale value 0 and a new code of 0, the first tick appears after the third clock edge following the change.
- R9: While rst_ni is low, all tick_o bits are 0. After reset, with all-zero configuration, every channel ticks every 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pre_cfg_i | input | 16 | Two 8-bit prescale values |
| sel_cfg_i | input | 20 | Five 4-bit channel source/divide codes |
| ext_tick_i | input | 2 | Asynchronous external tick inputs |
| tick_o | output | 5 | Per-channel single-cycle count enables |

## Verification
The external-source property looks back four cycles at ext_tick_i. It therefore assumes that the external inputs are low while reset is asserted and for the first cycles after reset, which the stimulus guarantees by holding them low until well after reset is released. The divide-by-2 period property fires only when the channel code and the prescale value have been stable for three sampled cycles. The stimulus changes configuration only at falling edges and then waits for a settling window before it measures pulse intervals. The external inputs are toggled at falling edges, with high and low phases of at least three cycles, so each edge lands cleanly in the synchroniser.

// File: rtl/tick_tree_pkg.sv
package tick_tree_pkg;
  localparam int unsigned NUM_CH  = 5;
  localparam int unsigned PRE_W   = 8;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned DIV_W   = 4;
  localparam int unsigned GRP0_CH = 2;  // channels below this use group 0

  localparam logic [SEL_W-1:0] SEL_EXT = SEL_W'(4);

  // terminal count for a select code; codes above 3 give the largest ratio
  function automatic logic [DIV_W-1:0] div_mask(input logic [SEL_W-1:0] code);
    logic [DIV_W-1:0] m;
    if (code < SEL_W'(DIV_W)) m = DIV_W'((1 << (code + 1)) - 1);
    else                      m = '1;
    return m;
  endfunction
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] val_i,
  output logic         en_o
);
  logic [W-1:0] cnt_q;

  // >= keeps the period bounded when the value drops below the count
  assign en_o = (cnt_q >= val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_o) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tt_divider.sv
module tt_divider
  import tick_tree_pkg::*;
#(
  parameter int unsigned SW = SEL_W,
  parameter int unsigned DW = DIV_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [SW-1:0] sel_i,
  output logic          tick_o
);
  logic [SW-1:0] sel_q;
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] mask;
  logic          restart;
  logic          last;

  assign mask    = div_mask(sel_i);
  assign restart = (sel_i != sel_q);
  assign last    = en_i && (cnt_q == mask);
  assign tick_o  = last && !restart;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else begin
      sel_q <= sel_i;
      if (restart)   cnt_q <= '0;
      else if (last) cnt_q <= '0;
      else if (en_i) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tt_ext_sync.sv
module tt_ext_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= ext_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q && !s3_q;
endmodule

// File: rtl/tick_tree.sv
module tick_tree
  import tick_tree_pkg::*;
#(
  parameter int unsigned N_CH  = NUM_CH,
  parameter int unsigned P_W   = PRE_W,
  parameter int unsigned S_W   = SEL_W,
  parameter int unsigned G0_CH = GRP0_CH
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2*P_W-1:0]   pre_cfg_i,
  input  logic [N_CH*S_W-1:0] sel_cfg_i,
  input  logic [1:0]         ext_tick_i,
  output logic [N_CH-1:0]    tick_o
);
  localparam int unsigned N_GRP = 2;

  logic [N_GRP-1:0] pre_en;
  logic [N_GRP-1:0] ext_rise;
  logic [N_CH-1:0]  src_tick;
  logic [N_CH-1:0]  tick_q;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    tt_prescaler #(.W(P_W)) u_pre (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .val_i (pre_cfg_i[g*P_W +: P_W]),
      .en_o  (pre_en[g])
    );
    tt_ext_sync u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ext_i (ext_tick_i[g]),
      .rise_o(ext_rise[g])
    );
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam int unsigned GRP = (c < G0_CH) ? 0 : 1;
    logic [S_W-1:0] code;
    logic           div_tick;

    assign code = sel_cfg_i[c*S_W +: S_W];

    tt_divider #(.SW(S_W), .DW(DIV_W)) u_div (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (pre_en[GRP]),
      .sel_i (code),
      .tick_o(div_tick)
    );

    assign src_tick[c] = (code == S_W'(SEL_EXT)) ? ext_rise[GRP] : div_tick;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= '0;
    else         tick_q <= src_tick;
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/tick_tree_chk.sv
module tick_tree_chk
  import tick_tree_pkg::*;
#(
  parameter int unsigned N_CH  = NUM_CH,
  parameter int unsigned P_W   = PRE_W,
  parameter int unsigned S_W   = SEL_W,
  parameter int unsigned G0_CH = GRP0_CH
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [2*P_W-1:0]    pre_cfg_i,
  input logic [N_CH*S_W-1:0] sel_cfg_i,
  input logic [1:0]          ext_tick_i,
  input logic [N_CH-1:0]     tick_o
);
  always @(negedge clk_i) begin
    if (!rst_ni) AST_RST_QUIET: assert (tick_o == '0); // R9
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    localparam int unsigned GRP = (c < G0_CH) ? 0 : 1;

    AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o[c] |=> !tick_o[c]); // R7

    AST_EXT_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o[c] && ($past(sel_cfg_i[c*S_W +: S_W], 1) == S_W'(SEL_EXT)))
      |-> ($past(ext_tick_i[GRP], 3) && !$past(ext_tick_i[GRP], 4))); // R6

    AST_DIV2_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(tick_o[c], 2)
       && ($past(sel_cfg_i[c*S_W +: S_W], 1) == '0)
       && ($past(sel_cfg_i[c*S_W +: S_W], 2) == '0)
       && ($past(sel_cfg_i[c*S_W +: S_W], 3) == '0)
       && ($past(pre_cfg_i[GRP*P_W +: P_W], 1) == '0)
       && ($past(pre_cfg_i[GRP*P_W +: P_W], 2) == '0)
       && ($past(pre_cfg_i[GRP*P_W +: P_W], 3) == '0))
      |-> tick_o[c]); // R3
  end
endmodule

bind tick_tree tick_tree_chk #(
  .N_CH(N_CH), .P_W(P_W), .S_W(S_W), .G0_CH(G0_CH)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pre_cfg_i (pre_cfg_i),
  .sel_cfg_i (sel_cfg_i),
  .ext_tick_i(ext_tick_i),
  .tick_o    (tick_o)
);

// File: tb/tick_tree_tb_top.sv
module tick_tree_tb_top;
  localparam int NCH = 5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] pre_cfg = '0;
  logic [19:0] sel_cfg = '0;
  logic [1:0]  ext = '0;
  logic [4:0]  tick;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit clr = 1'b0;
  bit done = 1'b0;
  int last_t [NCH];
  int ival   [NCH];
  int npulse [NCH];

  always #5 clk_i = ~clk_i;

  tick_tree dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pre_cfg_i (pre_cfg),
    .sel_cfg_i (sel_cfg),
    .ext_tick_i(ext),
    .tick_o    (tick)
  );

  always @(negedge clk_i) begin
    cyc++;
    for (int c = 0; c < NCH; c++) begin
      if (clr) begin
        npulse[c] = 0;
        ival[c] = 0;
      end else if (tick[c]) begin
        if (npulse[c] > 0) ival[c] = cyc - last_t[c];
        last_t[c] = cyc;
        npulse[c]++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk_i); clr = 1'b1;
    @(posedge clk_i); clr = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  function automatic int ratio(input int code);
    return (code <= 3) ? (2 << code) : 16;
  endfunction

  task automatic run_div(input int v0, input int v1, input int k);
    int cl [8] = '{0, 1, 2, 3, 5, 6, 7, 15};
    int codes [NCH];
    @(negedge clk_i);
    pre_cfg = {8'(v1), 8'(v0)};
    for (int c = 0; c < NCH; c++) begin
      codes[c] = cl[(k + c) % 8];
      sel_cfg[c*4 +: 4] = 4'(codes[c]);
    end
    wait_cyc(300);
    clear_mon();
    wait_cyc(320);
    for (int c = 0; c < NCH; c++) begin
      int v = (c < 2) ? v0 : v1;
      int exp = (v + 1) * ratio(codes[c]);
      chk(npulse[c] >= 2 && ival[c] == exp,
          (codes[c] <= 3) ? "R1 R2 R3 period" : "R1 R2 R5 period", ival[c], exp);
    end
  endtask

  task automatic pulse_ext(input int g, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); ext[g] = 1'b1;
      wait_cyc(3);
      ext[g] = 1'b0;
      wait_cyc(3);
    end
    wait_cyc(6);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9: quiet in reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk(tick == '0, "R9 reset", int'(tick), 0);
    end
    rst_ni = 1'b1;
    wait_cyc(10);
    clear_mon();
    wait_cyc(20);
    for (int c = 0; c < NCH; c++)
      chk(npulse[c] >= 2 && ival[c] == 2, "R9 default period", ival[c], 2);

    // R1 R2 R3 R5 sweep
    for (int k = 0; k < 8; k++) begin
      run_div(0, 0, k);
      run_div(1, 3, k);
      run_div(2, 0, k);
      run_div(5, 1, k);
    end

    // R4: external select, no activity
    @(negedge clk_i);
    pre_cfg = '0;
    sel_cfg = {5{4'd4}};
    wait_cyc(10);
    clear_mon();
    wait_cyc(100);
    for (int c = 0; c < NCH; c++)
      chk(npulse[c] == 0, "R4 no ext edge", npulse[c], 0);

    // R2 R4 R7: group routing of external edges
    clear_mon();
    pulse_ext(0, 5);
    for (int c = 0; c < NCH; c++)
      chk(npulse[c] == ((c < 2) ? 5 : 0), "R2 R4 ext0 routing", npulse[c], (c < 2) ? 5 : 0);
    clear_mon();
    pulse_ext(1, 4);
    for (int c = 0; c < NCH; c++)
      chk(npulse[c] == ((c < 2) ? 0 : 4), "R2 R4 ext1 routing", npulse[c], (c < 2) ? 0 : 4);

    // R7: long high level gives one pulse
    clear_mon();
    @(negedge clk_i); ext[1] = 1'b1;
    wait_cyc(50);
    for (int c = 2; c < NCH; c++)
      chk(npulse[c] == 1, "R7 one pulse per edge", npulse[c], 1);
    ext[1] = 1'b0;
    wait_cyc(6);

    // R6: synchroniser latency
    @(negedge clk_i); ext[0] = 1'b1;
    @(posedge clk_i); @(posedge clk_i);
    @(negedge clk_i);
    chk(tick[0] == 1'b0, "R6 early", int'(tick[0]), 0);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(tick[0] == 1'b1, "R6 latency", int'(tick[0]), 1);
    @(negedge clk_i);
    chk(tick[0] == 1'b0, "R7 single cycle", int'(tick[0]), 0);
    ext[0] = 1'b0;
    wait_cyc(6);

    // R8: restart on select change, various phases
    for (int d = 0; d < 16; d++) begin
      @(negedge clk_i);
      sel_cfg = '0;
      sel_cfg[3:0] = 4'd3;
      wait_cyc(20 + d);
      sel_cfg[3:0] = 4'd0;
      @(posedge clk_i); @(negedge clk_i);
      chk(tick[0] == 1'b0, "R8 edge1", int'(tick[0]), 0);
      @(posedge clk_i); @(negedge clk_i);
      chk(tick[0] == 1'b0, "R8 edge2", int'(tick[0]), 0);
      @(posedge clk_i); @(negedge clk_i);
      chk(tick[0] == 1'b1, "R8 edge3", int'(tick[0]), 1);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule